// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Controller

This block keeps one small direct-mapped, write-through cache coherent with its peers on a shared, atomic bus. Each line is either valid or invalid, and nothing else. A processor read that finds a valid line with a matching tag is answered in the same cycle, with no bus traffic. A read of an absent or invalid line is sent to the bus as a read. In the grant cycle the returned word is passed to the processor and fills the line, which then becomes valid. Every processor write goes to the bus as a write, whether or not the line is present. A write that misses allocates nothing. A write that hits refreshes the local word in the grant cycle.

The controller also watches a snoop port that shows the bus transactions of the other caches. A snooped write whose address matches a valid line invalidates that line. Many caches can therefore share a line for reading, but a write by any one of them removes every other copy. Snooped reads are ignored. If an invalidation lands on the same line as a read hit in the same cycle, the invalidation wins. The read is not answered in that cycle, and it is retried from the bus.

Addresses are word addresses. The low log2(LINES) bits select the line and the remaining bits are the tag. The processor holds each request steady until it is answered, and it issues one request at a time.

Top module: `wtsc_top`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` and `bus_req` are low while no request is present, and the first read of any address goes to the bus.
- R2: A read (`cpu_we`=0) whose line index holds a valid line with an equal tag raises `cpu_ready` in the same cycle, returns the stored word on `cpu_rdata`, and keeps `bus_req` low.
- R3: A read of an invalid line, or of a valid line with a different tag, raises `bus_req` with `bus_cmd`=0 (read) and `bus_addr`=`cpu_addr`. `cpu_ready` rises in the cycle `bus_gnt` is high, and `cpu_rdata` then equals `bus_rdata`. The line then holds that word and tag as valid, replacing any earlier tag at that index.
- R4: Every write (`cpu_we`=1), hit or miss, raises `bus_req` with `bus_cmd`=1 (write), `bus_addr`=`cpu_addr` and `bus_wdata`=`cpu_wdata`. `cpu_ready` rises in the grant cycle.
- R5: A write that misses leaves its line invalid, so a following read of that address goes to the bus.
- R6: A write that hits updates the stored word in its grant cycle, so a following read of that address hits and returns the written data.
- R7: A snooped write (`snp_valid`=1, `snp_cmd`=1) whose address matches a valid line invalidates that line, so the next read of that address goes to the bus.
- R8: A snooped read (`snp_cmd`=0) has no effect on the lines. A snooped write to a line that is not held, including one with the same index but another tag, also has no effect. A following read of a held address still hits.
- R9: When a snooped write invalidates the line of a read hit in the same cycle, `cpu_ready` stays low in that cycle and the read is then served through a bus read.
- R10: `cpu_ready` is never high while `cpu_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request present, held until answered |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` on a read |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 1 | 0 = bus read, 1 = bus write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_gnt | input | 1 | Transaction performed this cycle |
| bus_rdata | input | DW | Bus read data, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 1 | Snooped command, 0 = read, 1 = write |
| snp_addr | input | AW | Snooped address |

## Verification
The assertions rely on a few properties of the inputs. The processor keeps `cpu_req`, `cpu_we` and `cpu_addr` steady until `cpu_ready`. `bus_gnt` is high only while `bus_req` is high, for a single cycle. A snooped transaction never shares a cycle with this cache's own grant, because the bus is atomic. The bench's bus model waits at least one full cycle after seeing a request before it grants. It drives snoops only in the first cycle of a request or while the bus is idle, so a snoop can collide with a read hit but never with a grant. The bench keeps its own copies of memory and of the line states, so the expected hit or miss and data for each request are worked out without looking inside the design.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
   typedef enum logic {
      BUS_RD = 1'b0,
      BUS_WR = 1'b1
   } bus_cmd_e;
endpackage

// File: rtl/wtsc_line_store.sv
module wtsc_line_store
   import wtsc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int TAG_W = 4,
   parameter int DW    = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [DW-1:0]    rd_data,
   input  logic [IDX_W-1:0] sn_idx,
   input  logic [TAG_W-1:0] sn_tag,
   output logic             sn_hit,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [DW-1:0]    fill_data,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [DW-1:0]    upd_data,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx
);
   logic [LINES-1:0] vld;
   logic [TAG_W-1:0] tags [LINES];
   logic [DW-1:0]    words [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            v_q <= 1'b0;
         else if (inv_en && inv_idx == IDX_W'(i))
            v_q <= 1'b0;
         else if (fill_en && fill_idx == IDX_W'(i))
            v_q <= 1'b1;
      end
      assign vld[i] = v_q;
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tags[fill_idx]  <= fill_tag;
         words[fill_idx] <= fill_data;
      end else if (upd_en) begin
         words[upd_idx] <= upd_data;
      end
   end

   assign rd_hit  = vld[rd_idx] && (tags[rd_idx] == rd_tag);
   assign rd_data = words[rd_idx];
   assign sn_hit  = vld[sn_idx] && (tags[sn_idx] == sn_tag);

   // R7: an invalidated line reads as not valid in the following cycle
   assert_inval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |=> !vld[$past(inv_idx)]);

   // R3: a fill without a same-line invalidation leaves the line valid
   assert_fill_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !(inv_en && inv_idx == fill_idx)) |=> vld[$past(fill_idx)]);
endmodule

// File: rtl/wtsc_snoop_match.sv
module wtsc_snoop_match
   import wtsc_pkg::*;
#(
   parameter int AW    = 8,
   parameter int IDX_W = 4,
   localparam int TAG_W = AW - IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snp_valid,
   input  logic             snp_cmd,
   input  logic [AW-1:0]    snp_addr,
   output logic [IDX_W-1:0] sn_idx,
   output logic [TAG_W-1:0] sn_tag,
   input  logic             sn_hit,
   output logic             inv_en,
   output logic [IDX_W-1:0] inv_idx
);
   assign sn_idx  = snp_addr[IDX_W-1:0];
   assign sn_tag  = snp_addr[AW-1:IDX_W];
   assign inv_en  = snp_valid && (snp_cmd == BUS_WR) && sn_hit;
   assign inv_idx = sn_idx;

   // R8: only a snooped write that hits a held line may invalidate
   assert_snoop_read_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd == BUS_RD) |-> !inv_en);
endmodule

// File: rtl/wtsc_req_ctrl.sv
module wtsc_req_ctrl
   import wtsc_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic          line_hit,
   input  logic          snoop_kill,
   input  logic [DW-1:0] line_data,
   input  logic          bus_gnt,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_req,
   output bus_cmd_e      bus_cmd,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          fill_en,
   output logic          upd_en
);
   logic local_ok;
   logic grant_done;

   assign local_ok   = cpu_req && !cpu_we && line_hit && !snoop_kill;
   assign bus_req    = cpu_req && (cpu_we || !line_hit);
   assign bus_cmd    = cpu_we ? BUS_WR : BUS_RD;
   assign grant_done = bus_gnt && bus_req;
   assign cpu_ready  = local_ok || grant_done;
   assign cpu_rdata  = grant_done ? bus_rdata : line_data;
   assign fill_en    = grant_done && !cpu_we;
   assign upd_en     = grant_done && cpu_we && line_hit;

   // R2: completion without a grant is a local read with no bus request
   assert_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !bus_gnt) |-> (!bus_req && !cpu_we));

   // R4: every write asks for a bus write
   assert_write_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we) |-> (bus_req && bus_cmd == BUS_WR));

   // R10: no completion without a request
   assert_ready_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);
endmodule

// File: rtl/wtsc_top.sv
module wtsc_top
   import wtsc_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int LINES = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ready,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   output logic          bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_gnt,
   input  logic [DW-1:0] bus_rdata,
   input  logic          snp_valid,
   input  logic          snp_cmd,
   input  logic [AW-1:0] snp_addr
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = AW - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("wtsc_top: LINES must be a power of two of at least 2");
   end
   if (AW <= IDX_W) begin : g_bad_aw
      $error("wtsc_top: AW must exceed the index width");
   end
   if (DW < 1) begin : g_bad_dw
      $error("wtsc_top: DW must be positive");
   end

   logic [IDX_W-1:0] cpu_idx;
   logic [TAG_W-1:0] cpu_tag;
   logic [IDX_W-1:0] sn_idx;
   logic [TAG_W-1:0] sn_tag;
   logic             sn_hit;
   logic             inv_en;
   logic [IDX_W-1:0] inv_idx;
   logic             line_hit;
   logic [DW-1:0]    line_data;
   logic             snoop_kill;
   logic             fill_en;
   logic             upd_en;
   bus_cmd_e         cmd_q;

   assign cpu_idx    = cpu_addr[IDX_W-1:0];
   assign cpu_tag    = cpu_addr[AW-1:IDX_W];
   assign snoop_kill = inv_en && (inv_idx == cpu_idx);
   assign bus_addr   = cpu_addr;
   assign bus_wdata  = cpu_wdata;
   assign bus_cmd    = cmd_q;

   wtsc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (cpu_idx),
      .rd_tag    (cpu_tag),
      .rd_hit    (line_hit),
      .rd_data   (line_data),
      .sn_idx    (sn_idx),
      .sn_tag    (sn_tag),
      .sn_hit    (sn_hit),
      .fill_en   (fill_en),
      .fill_idx  (cpu_idx),
      .fill_tag  (cpu_tag),
      .fill_data (bus_rdata),
      .upd_en    (upd_en),
      .upd_idx   (cpu_idx),
      .upd_data  (cpu_wdata),
      .inv_en    (inv_en),
      .inv_idx   (inv_idx)
   );

   wtsc_snoop_match #(.AW(AW), .IDX_W(IDX_W)) u_snoop (
      .clk       (clk),
      .rst_n     (rst_n),
      .snp_valid (snp_valid),
      .snp_cmd   (snp_cmd),
      .snp_addr  (snp_addr),
      .sn_idx    (sn_idx),
      .sn_tag    (sn_tag),
      .sn_hit    (sn_hit),
      .inv_en    (inv_en),
      .inv_idx   (inv_idx)
   );

   wtsc_req_ctrl #(.DW(DW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_req    (cpu_req),
      .cpu_we     (cpu_we),
      .line_hit   (line_hit),
      .snoop_kill (snoop_kill),
      .line_data  (line_data),
      .bus_gnt    (bus_gnt),
      .bus_rdata  (bus_rdata),
      .bus_req    (bus_req),
      .bus_cmd    (cmd_q),
      .cpu_ready  (cpu_ready),
      .cpu_rdata  (cpu_rdata),
      .fill_en    (fill_en),
      .upd_en     (upd_en)
   );

   // R9: a read whose line is killed by a snoop is retried on the bus next cycle
   assert_retry_after_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && snoop_kill && !bus_gnt) |=> (!cpu_req || bus_req));

   // R3: a read miss completes only through a grant, with the bus read command
   assert_miss_via_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !line_hit) |-> (bus_req && bus_cmd == 1'b0 && (cpu_ready == bus_gnt)));
endmodule

// File: tb/wtsc_top_bench.sv
module wtsc_top_bench;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int LINES = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_gnt = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          snp_valid = 1'b0;
   logic          snp_cmd = 1'b0;
   logic [AW-1:0] snp_addr = '0;

   always #10 clk = ~clk;

   wtsc_top #(.AW(AW), .DW(DW), .LINES(LINES)) u_wtsc_top (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr)
   );

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          uses_bus;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] mem [256];
   logic          mv [LINES];
   logic [3:0]    mt [LINES];
   int            total = 0;
   int            fails = 0;
   bit            done = 0;

   task automatic chk(bit ok, string what, int act, int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   // bus model: grants after 1..3 cycles, one cycle long
   initial begin
      int wcnt = 1;
      int sel = 0;
      logic          g_cmd;
      logic [AW-1:0] g_addr;
      logic [DW-1:0] g_data;
      forever begin
         @(negedge clk);
         #2;
         if (bus_req) begin
            if (wcnt == 0) begin
               bus_gnt = 1'b1;
               bus_rdata = mem[bus_addr];
               g_cmd = bus_cmd;
               g_addr = bus_addr;
               g_data = bus_wdata;
               @(posedge clk);
               #1;
               bus_gnt = 1'b0;
               if (g_cmd) mem[g_addr] = g_data;
               sel = (sel + 1) % 3;
               wcnt = sel + 1;
            end else begin
               wcnt--;
            end
         end else begin
            wcnt = sel + 1;
         end
      end
   end

   // monitor: compares each completion with the scoreboard front
   initial begin
      bit seen = 0;
      exp_t e;
      forever begin
         @(negedge clk);
         #6;
         if (rst_n && bus_gnt && !seen && sb.size() > 0) begin
            e = sb[0];
            seen = 1;
            chk(bus_cmd == e.we, {e.tag, " bus_cmd"}, int'(bus_cmd), int'(e.we));
            chk(bus_addr == e.addr, {e.tag, " bus_addr"}, int'(bus_addr), int'(e.addr));
            if (e.we)
               chk(bus_wdata == e.data, {e.tag, " bus_wdata R4"}, int'(bus_wdata), int'(e.data));
         end
         if (rst_n && cpu_ready) begin
            if (sb.size() == 0) begin
               chk(0, "R10 completion with nothing pending", 1, 0);
            end else begin
               e = sb.pop_front();
               chk(seen == e.uses_bus, {e.tag, " bus used"}, int'(seen), int'(e.uses_bus));
               if (!e.we)
                  chk(cpu_rdata == e.data, {e.tag, " rdata"}, int'(cpu_rdata), int'(e.data));
            end
            seen = 0;
         end
      end
   end

   task automatic op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, string tag,
                     bit sn = 0, bit sn_wr = 1, logic [AW-1:0] sa = '0, logic [DW-1:0] sd = '0);
      exp_t e;
      bit hit;
      @(negedge clk);
      if (sn && sn_wr) begin
         if (mv[sa[3:0]] && mt[sa[3:0]] == sa[7:4]) mv[sa[3:0]] = 0;
         mem[sa] = sd;
      end
      hit = mv[a[3:0]] && mt[a[3:0]] == a[7:4];
      e.we = we;
      e.addr = a;
      e.data = we ? wd : mem[a];
      e.uses_bus = we || !hit;
      e.tag = tag;
      if (!we) begin
         mv[a[3:0]] = 1;
         mt[a[3:0]] = a[7:4];
      end
      sb.push_back(e);
      cpu_req = 1;
      cpu_we = we;
      cpu_addr = a;
      cpu_wdata = wd;
      snp_valid = sn;
      snp_cmd = sn_wr;
      snp_addr = sa;
      forever begin
         #6;
         if (cpu_ready) break;
         @(negedge clk);
         snp_valid = 0;
      end
      @(negedge clk);
      snp_valid = 0;
      cpu_req = 0;
      #6;
      chk(cpu_ready == 1'b0, "R10 ready without request", int'(cpu_ready), 0);
   endtask

   task automatic snoop(bit wr, logic [AW-1:0] sa, logic [DW-1:0] sd);
      @(negedge clk);
      if (wr) begin
         if (mv[sa[3:0]] && mt[sa[3:0]] == sa[7:4]) mv[sa[3:0]] = 0;
         mem[sa] = sd;
      end
      snp_valid = 1;
      snp_cmd = wr;
      snp_addr = sa;
      @(negedge clk);
      snp_valid = 0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = DW'(i * 3 + 7);
      for (int i = 0; i < LINES; i++) begin
         mv[i] = 0;
         mt[i] = 0;
      end
      repeat (3) @(negedge clk);
      #6;
      chk(cpu_ready == 0, "R1 reset ready", int'(cpu_ready), 0);
      chk(bus_req == 0, "R1 reset bus_req", int'(bus_req), 0);
      @(negedge clk);
      rst_n = 1;
      #6;
      chk(bus_req == 0, "R1 idle bus_req", int'(bus_req), 0);

      op(0, 8'h12, 0, "R1 R3 first read miss");
      op(0, 8'h12, 0, "R2 read hit");
      op(0, 8'h22, 0, "R3 replace same index");
      op(0, 8'h12, 0, "R3 refetch after replace");
      op(1, 8'h12, 16'hBEEF, "R4 write hit");
      op(0, 8'h12, 0, "R6 read after write hit");
      op(1, 8'h35, 16'h1234, "R4 write miss");
      op(0, 8'h35, 0, "R5 read after write miss");
      snoop(1, 8'h12, 16'h1111);
      op(0, 8'h12, 0, "R7 read after snooped write");
      snoop(0, 8'h12, 0);
      op(0, 8'h12, 0, "R8 hit after snooped read");
      snoop(1, 8'h42, 16'h4242);
      op(0, 8'h12, 0, "R8 hit after other-tag snooped write");
      op(0, 8'h12, 0, "R9 snoop kills read hit", 1, 1, 8'h12, 16'h2222);
      op(0, 8'h12, 0, "R8 hit with unrelated snoop", 1, 1, 8'h57, 16'h5757);
      op(0, 8'h12, 0, "R8 hit with same-line snooped read", 1, 0, 8'h12, 0);
      for (int i = 0; i < LINES; i++) op(0, {4'h6, 4'(i)}, 0, "R3 sweep miss");
      for (int i = 0; i < LINES; i++) op(0, {4'h6, 4'(i)}, 0, "R2 sweep hit");
      for (int i = 0; i < LINES; i += 2) op(1, {4'h6, 4'(i)}, DW'(16'hA000 + i), "R4 sweep write");
      for (int i = 0; i < LINES; i++) op(0, {4'h6, 4'(i)}, 0, "R6 sweep reread");
      for (int i = 1; i < LINES; i += 2) snoop(1, {4'h6, 4'(i)}, DW'(16'hC000 + i));
      for (int i = 0; i < LINES; i++) op(0, {4'h6, 4'(i)}, 0, "R7 sweep after snoops");
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk(0, "watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule